// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block keeps a device in reset for a fixed, counted number of ticks after the supply rises above its brown-out threshold. It runs on a slow internal tick clock. It receives the supply-good flag from an analog comparator, which arrives asynchronously, and passes it through a two-flop synchronizer before using it. When the delay is enabled, an `CNT_W`-bit counter must run through its full range before the reset request is released. With the default width of 11 bits the delay is 2048 ticks, which is roughly 65.5 ms at a 32 µs tick. The exact time follows the tick period, so it varies from one die to another.

If the supply falls below the threshold at any point, the sequencer returns to its brown-out state and clears the counter. The full delay then starts again when the supply recovers. A configuration input selects whether the delay is used: a 0 enables the delay, and a 1 releases reset as soon as the synchronized supply is good. When reset is released, a one-tick strobe marks the moment.

Top module: `pwrup_delay_seq`

## Requirements
- R1: While `rstN` is low, `holdRst` is 1 and `releasePulse` is 0.
- R2: With `delayCfgN` = 1, `holdRst` goes low after the 3rd rising edge of `clk`. Edge 1 is the first edge at which `supplyOk` is sampled high. Edges 1 and 2 are spent in the synchronizer.
- R3: With `delayCfgN` = 0, `holdRst` is still 1 after edge 2+2^CNT_W and goes low after edge 3+2^CNT_W, with edges counted as in R2. At the default width this is 2048 ticks of delay.
- R4: `releasePulse` is 1 for exactly the one tick in which `holdRst` first reads 0, and is 0 at all other times.
- R5: When `supplyOk` falls, `holdRst` is 1 after the 3rd rising edge that samples it low. This holds whether the block was counting or already released.
- R6: A brown-out at any point during the count clears the counter, so the next rise of `supplyOk` gets the full delay of R3.
- R7: `delayCfgN` is used only when leaving the brown-out state. Changing it while the count runs leaves the delay of R3 unchanged.
- R8: While counting, the counter advances by exactly one per tick. It is held at zero in the brown-out state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow internal tick clock |
| rstN | input | 1 | Asynchronous active-low initialisation of the sequencer |
| supplyOk | input | 1 | Asynchronous supply-above-threshold flag from the comparator |
| delayCfgN | input | 1 | Delay enable configuration bit, active low (0 = delay used) |
| holdRst | output | 1 | Reset request to the device, 1 = hold in reset |
| releasePulse | output | 1 | One-tick strobe on the release of reset |

## Verification
The assertions assume that `supplyOk` changes only between tick edges. Under that assumption the synchronizer output is a clean two-tick delayed copy of it. They also assume that `delayCfgN` is static apart from deliberate changes, which R7 covers. The bench drives every input on the falling edge of `clk`, so no input ever moves at an active edge. It runs with a 4-bit counter, which allows a sweep of every brown-out position across the whole count and beyond the release.

// File: rtl/pud_pkg.sv
package pud_pkg;
  typedef enum logic [1:0] {
    ST_BROWN = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } pud_state_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } pud_strb_t;
endpackage

// File: rtl/pud_sync.sv
module pud_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

  // R2
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    chain[1] == $past(chain[0]));
endmodule

// File: rtl/pud_count.sv
module pud_count
  import pud_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  pud_strb_t strb,
  output logic      cntDone
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (strb.clr) cnt <= '0;
    else if (strb.inc) cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == CNT_MAX);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> cnt == '0);
endmodule

// File: rtl/pud_ctrl.sv
module pud_ctrl
  import pud_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supGood,
  input  logic      delayCfgN,
  input  logic      cntDone,
  output pud_strb_t strb,
  output logic      holdRst,
  output logic      releasePulse
);
  pud_state_e state, nextState;
  logic relPulseQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_BROWN: if (supGood) nextState = delayCfgN ? ST_RUN : ST_COUNT;
      ST_COUNT: if (!supGood) nextState = ST_BROWN;
                else if (cntDone) nextState = ST_RUN;
      ST_RUN:   if (!supGood) nextState = ST_BROWN;
      default:  nextState = ST_BROWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_BROWN;
      relPulseQ <= 1'b0;
    end else begin
      state     <= nextState;
      relPulseQ <= (nextState == ST_RUN) && (state != ST_RUN);
    end
  end

  assign strb.clr     = (state == ST_BROWN);
  assign strb.inc     = (state == ST_COUNT);
  assign holdRst      = (state != ST_RUN);
  assign releasePulse = relPulseQ;

  // R5
  brownout_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supGood |=> state == ST_BROWN);
  // R3
  full_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_COUNT) |-> $past(cntDone));
  // R2
  bypass_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_BROWN) |-> $past(delayCfgN));
  // R4
  pulse_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    releasePulse |-> (state == ST_RUN && $past(state) != ST_RUN));
endmodule

// File: rtl/pwrup_delay_seq.sv
module pwrup_delay_seq
  import pud_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic delayCfgN,
  output logic holdRst,
  output logic releasePulse
);
  logic      supGood;
  logic      cntDone;
  pud_strb_t strb;

  pud_sync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(supplyOk), .syncOut(supGood)
  );

  pud_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .supGood(supGood), .delayCfgN(delayCfgN),
    .cntDone(cntDone), .strb(strb), .holdRst(holdRst),
    .releasePulse(releasePulse)
  );

  pud_count #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .strb(strb), .cntDone(cntDone)
  );
endmodule

// File: tb/pwrup_delay_seq_test.sv
module pwrup_delay_seq_test;
  localparam int W   = 4;
  localparam int DLY = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic delayCfgN = 1'b0;
  logic holdRst, releasePulse;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwrup_delay_seq #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .delayCfgN(delayCfgN),
    .holdRst(holdRst), .releasePulse(releasePulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise supplyOk at a negedge, then count edges until holdRst reads low.
  // Each sample is taken at the negedge following the rising edge.
  task automatic riseAndMeasure(input string req, input int expEdges, input bit flipCfg);
    int n = 0;
    int pulses = 0;
    int pulseAt = -1;
    supplyOk = 1'b1;
    while (n < expEdges + 4) begin
      @(negedge clk);
      n++;
      if (flipCfg && n == 5) delayCfgN = ~delayCfgN;
      if (releasePulse) begin pulses++; pulseAt = n; end
      if (n == expEdges - 1) check({req, " still held"}, holdRst, 1);
      if (n == expEdges)     check({req, " released"}, holdRst, 0);
    end
    check("R4 pulse count", pulses, 1);
    check("R4 pulse position", pulseAt, expEdges);
  endtask

  task automatic dropAndCheck();
    supplyOk = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 held after drop", holdRst, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 holdRst in reset", holdRst, 1);
    check("R1 releasePulse in reset", releasePulse, 0);
    supplyOk = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 held during reset despite supply", holdRst, 1);
    supplyOk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 holdRst after reset", holdRst, 1);

    // R2 bypass
    delayCfgN = 1'b1;
    riseAndMeasure("R2", 3, 1'b0);
    dropAndCheck();

    // R3 and R8: full delay
    delayCfgN = 1'b0;
    riseAndMeasure("R3", 3 + DLY, 1'b0);
    dropAndCheck();

    // R7: config flipped to 1 mid-count has no effect
    delayCfgN = 1'b0;
    riseAndMeasure("R7", 3 + DLY, 1'b1);
    dropAndCheck();
    delayCfgN = 1'b0;

    // R6/R5: brown-out at every position through the count and after release
    for (int d = 1; d <= DLY + 6; d++) begin
      supplyOk = 1'b1;
      repeat (d) @(negedge clk);
      dropAndCheck();
      riseAndMeasure("R6", 3 + DLY, 1'b0);
      dropAndCheck();
    end

    // R4: no pulse while steadily running
    supplyOk = 1'b1;
    repeat (DLY + 3) @(negedge clk);
    begin
      int extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (releasePulse) extra++;
      end
      check("R4 no pulse in steady run", extra, 0);
      check("R4 run state held", holdRst, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule